// File: doc/BRIEF.md
# Three-Leg Gate Command Conditioner with Interlock and Dead Time

This block sits between a PWM generator and the gate drivers of a three-phase inverter bridge. Every leg receives two active-high commands, one asking for the upper switch and one for the lower switch. Each command passes through a digital pulse-rejection filter. The filtered pair then goes to an arbiter. The arbiter never lets both switches of a leg conduct together, and it holds both gates low for a minimum idle time before it turns either gate on.

When both commands of a leg are high, the command that became high first keeps the leg. The later command has no effect until the first one is withdrawn. The leg is not simply shut off in this case. A global shutdown input pulls every gate low in the same cycle and restarts the idle timer. All command inputs are expected to be synchronous to `clk`. The filter length and the dead-time length are parameters counted in clock cycles. With a 100 MHz clock the defaults of 29 and 38 cycles give 290 ns and 380 ns.

All pins are plain control levels. There is no data stream and no handshake, so nothing here is subject to back-pressure.

Top module: `tri_leg_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, every `hi_gate` and `lo_gate` bit is 0, and the filter and dead-time counters are cleared. The dead-time count therefore starts over when reset is released.
- R2: Commands are positive logic. A command that is 1, owned, and past the dead time drives its gate to 1. With the leg idle and the dead time elapsed, a command that changes before clock edge 1 moves its gate after edge FILT_CYC+1.
- R3: A command level is accepted only after FILT_CYC consecutive sampled cycles at the new level. A pulse of FILT_CYC-1 cycles or shorter, in either direction, leaves the gate unchanged.
- R4: `hi_gate[i]` and `lo_gate[i]` are never 1 in the same cycle.
- R5: If a leg is driving one gate and the opposite command then rises, the driven gate stays on and the opposite gate stays off for as long as the first command remains 1.
- R6: If both filtered commands of a leg rise in the same cycle, the leg stays off. Once one of them is withdrawn, the remaining one takes the leg.
- R7: When the owning command is withdrawn while the other command is still 1, the other gate turns on exactly DEAD_CYC cycles after the owning gate turned off.
- R8: After any gate turns off, and after reset, both gates of that leg stay 0 for at least DEAD_CYC cycles before either one turns on.
- R9: While `force_off` is 1, every gate is 0 in the same cycle. Once `force_off` has been sampled 1 at an edge, no gate turns on until DEAD_CYC edges after the last such edge.
- R10: The legs work independently. The commands of one leg never affect the gates of another leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_off | input | 1 | Global shutdown: all gates low at once |
| hi_cmd | input | N_LEGS | Upper-switch on request, one bit per leg |
| lo_cmd | input | N_LEGS | Lower-switch on request, one bit per leg |
| hi_gate | output | N_LEGS | Upper-switch gate enable, one bit per leg |
| lo_gate | output | N_LEGS | Lower-switch gate enable, one bit per leg |

## Verification
Two functions can act in the same cycle: the withdrawal of the owning command, which starts the dead-time count, and the qualification of the opposite command by its filter. A third pairing is a shutdown that arrives in the cycle a handover would otherwise complete. The directed phases make these coincide on purpose: one handover from upper to lower, one simultaneous rise, and one shutdown applied while a gate is on. Long random runs then mix command holds near the filter length with short shutdown bursts. The bench judges each cycle against its own timestamp model of filter runs, command rise order and the last gate-off edge. A separate gap monitor confirms on the output pins that no turn-on follows a turn-off by fewer than DEAD_CYC cycles.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HI   = 2'd1,
    OWN_LO   = 2'd2
  } owner_e;

  // Decide which side holds the leg from the current and previous filtered
  // requests; the side that was already high keeps precedence.
  function automatic owner_e pick_owner(input logic hi, input logic lo,
                                        input logic hi_prev, input logic lo_prev,
                                        input owner_e cur);
    if (hi && lo) begin
      if (hi_prev && !lo_prev) return OWN_HI;
      if (lo_prev && !hi_prev) return OWN_LO;
      return cur;
    end
    if (hi) return OWN_HI;
    if (lo) return OWN_LO;
    return OWN_NONE;
  endfunction

endpackage

// File: rtl/cmd_filter.sv
module cmd_filter #(
  parameter int unsigned FILT_CYC = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int unsigned CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] RUN_LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      clean <= 1'b0;
    end else if (raw == clean) begin
      run_q <= '0;
    end else if (run_q == RUN_LAST) begin
      clean <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R3: the qualified level only ever moves toward the level just sampled
  assert_filter_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> ($past(raw) == clean));

endmodule

// File: rtl/leg_arbiter.sv
module leg_arbiter
  import tlg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_on,
  output logic lo_on
);
  localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] GAP_LAST = CW'(DEAD_CYC - 1);
  localparam int unsigned OW = $clog2(DEAD_CYC + 1);

  owner_e        own_q, own_n;
  logic          hi_d, lo_d;
  logic [CW-1:0] gap_q;
  logic          gap_done;

  assign gap_done = (gap_q == GAP_LAST);

  always_comb own_n = pick_owner(hi_req, lo_req, hi_d, lo_d, own_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      hi_d  <= 1'b0;
      lo_d  <= 1'b0;
      gap_q <= '0;
      hi_on <= 1'b0;
      lo_on <= 1'b0;
    end else begin
      own_q <= own_n;
      hi_d  <= hi_req;
      lo_d  <= lo_req;
      if (kill || hi_on || lo_on) gap_q <= '0;
      else if (!gap_done)         gap_q <= gap_q + 1'b1;
      if (kill) begin
        hi_on <= 1'b0;
        lo_on <= 1'b0;
      end else if (hi_on) begin
        hi_on <= hi_req;
      end else if (lo_on) begin
        lo_on <= lo_req;
      end else if (gap_done) begin
        hi_on <= (own_n == OWN_HI);
        lo_on <= (own_n == OWN_LO);
      end
    end
  end

  // Independent idle-run counter for the dead-time check
  logic [OW-1:0] off_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  off_run <= '0;
    else if (hi_on || lo_on)     off_run <= '0;
    else if (off_run < OW'(DEAD_CYC)) off_run <= off_run + 1'b1;
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_on && lo_on));

  assert_dead_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_on) || $rose(lo_on)) |-> (off_run >= OW'(DEAD_CYC)));

  assert_hi_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_on && hi_req && !kill) |=> hi_on);

  assert_lo_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_on && lo_req && !kill) |=> lo_on);

  assert_kill_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!hi_on && !lo_on));

endmodule

// File: rtl/half_bridge_leg.sv
module half_bridge_leg #(
  parameter int unsigned FILT_CYC = 29,
  parameter int unsigned DEAD_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic hi_cmd,
  input  logic lo_cmd,
  output logic hi_gate,
  output logic lo_gate
);
  logic [1:0] raw_v, clean_v;
  logic       hi_on, lo_on;

  assign raw_v = {lo_cmd, hi_cmd};

  for (genvar s = 0; s < 2; s++) begin : g_side
    cmd_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_v[s]),
      .clean (clean_v[s])
    );
  end

  leg_arbiter #(.DEAD_CYC(DEAD_CYC)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill   (kill),
    .hi_req (clean_v[0]),
    .lo_req (clean_v[1]),
    .hi_on  (hi_on),
    .lo_on  (lo_on)
  );

  assign hi_gate = hi_on & ~kill;
  assign lo_gate = lo_on & ~kill;

  // R9: shutdown wins in the very cycle it is applied
  always_comb begin
    assert_kill_now_R9: assert (!(kill && (hi_gate || lo_gate)));
  end

endmodule

// File: rtl/tri_leg_gate_ctrl.sv
module tri_leg_gate_ctrl #(
  parameter int unsigned N_LEGS   = 3,
  parameter int unsigned FILT_CYC = 29,
  parameter int unsigned DEAD_CYC = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_off,
  input  logic [N_LEGS-1:0] hi_cmd,
  input  logic [N_LEGS-1:0] lo_cmd,
  output logic [N_LEGS-1:0] hi_gate,
  output logic [N_LEGS-1:0] lo_gate
);

  for (genvar i = 0; i < N_LEGS; i++) begin : g_leg
    half_bridge_leg #(.FILT_CYC(FILT_CYC), .DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (force_off),
      .hi_cmd  (hi_cmd[i]),
      .lo_cmd  (lo_cmd[i]),
      .hi_gate (hi_gate[i]),
      .lo_gate (lo_gate[i])
    );
  end

  assert_gates_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate & lo_gate) == '0);

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (hi_gate == '0 && lo_gate == '0));

endmodule

// File: tb/tri_leg_gate_ctrl_bench.sv
module tri_leg_gate_ctrl_bench;
  localparam int N = 3;
  localparam int F = 29;
  localparam int D = 38;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         force_off = 1'b0;
  logic [N-1:0] hi_cmd = '0;
  logic [N-1:0] lo_cmd = '0;
  logic [N-1:0] hi_gate, lo_gate;

  always #5 clk = ~clk;

  tri_leg_gate_ctrl #(.N_LEGS(N), .FILT_CYC(F), .DEAD_CYC(D)) u_tri_leg_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .force_off(force_off),
    .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  int    nvec = 0;
  int    nfail = 0;
  bit    done = 0;
  string phase_tag = "R1";

  // ---------------- timestamp reference model ----------------
  int ecount = 0;
  bit m_hi [N];
  bit m_lo [N];
  bit mf   [N][2];
  bit lraw [N][2];
  int run  [N][2];
  int rise_t [N][2];
  int fall_t [N];
  bit own_hi, own_lo, was_on, rawv;

  always @(posedge clk) begin
    ecount++;
    for (int l = 0; l < N; l++) begin
      if (!rst_n) begin
        m_hi[l] = 0; m_lo[l] = 0; fall_t[l] = ecount;
        for (int s = 0; s < 2; s++) begin
          mf[l][s] = 0; lraw[l][s] = 0; run[l][s] = 0; rise_t[l][s] = 0;
        end
      end else begin
        own_hi = mf[l][0] && (!mf[l][1] || rise_t[l][0] < rise_t[l][1]);
        own_lo = mf[l][1] && (!mf[l][0] || rise_t[l][1] < rise_t[l][0]);
        was_on = m_hi[l] || m_lo[l];
        if (force_off) begin m_hi[l] = 0; m_lo[l] = 0; end
        else if (m_hi[l]) m_hi[l] = mf[l][0];
        else if (m_lo[l]) m_lo[l] = mf[l][1];
        else if (ecount - fall_t[l] >= D) begin m_hi[l] = own_hi; m_lo[l] = own_lo; end
        if (force_off || was_on) fall_t[l] = ecount;
        for (int s = 0; s < 2; s++) begin
          rawv = (s == 0) ? hi_cmd[l] : lo_cmd[l];
          if (rawv == lraw[l][s]) run[l][s]++; else run[l][s] = 1;
          lraw[l][s] = rawv;
          if (run[l][s] >= F && rawv != mf[l][s]) begin
            mf[l][s] = rawv;
            if (rawv) rise_t[l][s] = ecount;
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  int low_run [N];
  bit [1:0] prev_act [N];

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, ecount);
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int l = 0; l < N; l++) begin
      logic [1:0] act, exp;
      act = {hi_gate[l], lo_gate[l]};
      exp = {m_hi[l] & ~force_off, m_lo[l] & ~force_off};
      chk(phase_tag, act, exp);
      chk("R4", int'(act == 2'b11), 0);
      if (!rst_n) low_run[l] = D;
      else if (act == 2'b00) begin
        if (low_run[l] < D) low_run[l]++;
      end else begin
        if (prev_act[l] == 2'b00) chk("R8", int'(low_run[l] >= D), 1);
        low_run[l] = 0;
      end
      prev_act[l] = act;
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int pick_hold();
    if ($urandom_range(0, 9) < 3) return $urandom_range(1, F + 2);
    return $urandom_range(F, 4 * (F + D));
  endfunction

  int hold_h [N];
  int hold_l [N];
  int kill_hold = 0;

  initial begin
    void'($urandom(32'd20240917));
    for (int l = 0; l < N; l++) begin low_run[l] = D; prev_act[l] = 2'b00; end

    // R1: outputs held low during reset even with commands applied
    phase_tag = "R1";
    hi_cmd = 3'b011; lo_cmd = 3'b100;
    steps(F + 4);
    chk("R1", int'({hi_gate, lo_gate}), 0);
    hi_cmd = '0; lo_cmd = '0;
    steps(2);
    rst_n = 1'b1;
    steps(F + D + 10);

    // R2: plain turn-on and turn-off latency on leg 0
    phase_tag = "R2";
    hi_cmd[0] = 1'b1;
    steps(F);
    chk("R2", int'(hi_gate[0]), 0);
    step();
    chk("R2", int'(hi_gate[0]), 1);
    hi_cmd[0] = 1'b0;
    steps(F);
    chk("R2", int'(hi_gate[0]), 1);
    step();
    chk("R2", int'(hi_gate[0]), 0);
    steps(D + 5);

    // R3: short pulses in both directions are rejected
    phase_tag = "R3";
    lo_cmd[0] = 1'b1;
    steps(F - 1);
    lo_cmd[0] = 1'b0;
    steps(2 * F);
    chk("R3", int'(lo_gate[0]), 0);
    lo_cmd[0] = 1'b1;
    steps(F + 2);
    chk("R3", int'(lo_gate[0]), 1);
    lo_cmd[0] = 1'b0;
    steps(F - 1);
    lo_cmd[0] = 1'b1;
    steps(2 * F);
    chk("R3", int'(lo_gate[0]), 1);
    lo_cmd[0] = 1'b0;
    steps(F + D + 5);

    // R5 then R7: first command keeps the leg, handover after dead time
    phase_tag = "R5";
    hi_cmd[0] = 1'b1;
    steps(F + 3);
    lo_cmd[0] = 1'b1;
    steps(3 * F);
    chk("R5", int'({hi_gate[0], lo_gate[0]}), 2);
    phase_tag = "R7";
    hi_cmd[0] = 1'b0;
    steps(F + 1);
    chk("R7", int'({hi_gate[0], lo_gate[0]}), 0);
    steps(D - 1);
    chk("R7", int'(lo_gate[0]), 0);
    step();
    chk("R7", int'(lo_gate[0]), 1);
    lo_cmd[0] = 1'b0;
    steps(F + D + 5);

    // R6: simultaneous rise keeps the leg off until one side lets go
    phase_tag = "R6";
    hi_cmd[0] = 1'b1; lo_cmd[0] = 1'b1;
    steps(3 * F + D);
    chk("R6", int'({hi_gate[0], lo_gate[0]}), 0);
    hi_cmd[0] = 1'b0;
    steps(F);
    chk("R6", int'(lo_gate[0]), 0);
    step();
    chk("R6", int'(lo_gate[0]), 1);

    // R9: shutdown drops the gate at once and restarts the dead time
    phase_tag = "R9";
    force_off = 1'b1;
    step();
    chk("R9", int'(lo_gate[0]), 0);
    steps(2);
    force_off = 1'b0;
    steps(D - 1);
    chk("R9", int'(lo_gate[0]), 0);
    step();
    chk("R9", int'(lo_gate[0]), 1);
    lo_cmd[0] = 1'b0;
    steps(F + D + 5);

    // R10: legs act independently, then constrained random traffic
    phase_tag = "R10";
    hi_cmd = 3'b010; lo_cmd = 3'b100;
    steps(F + 2);
    chk("R10", int'({hi_gate, lo_gate}), 6'b010_100);
    for (int l = 0; l < N; l++) begin hold_h[l] = pick_hold(); hold_l[l] = pick_hold(); end
    for (int c = 0; c < 15000; c++) begin
      for (int l = 0; l < N; l++) begin
        if (hold_h[l] == 0) begin hi_cmd[l] = ~hi_cmd[l]; hold_h[l] = pick_hold(); end
        else hold_h[l]--;
        if (hold_l[l] == 0) begin lo_cmd[l] = ~lo_cmd[l]; hold_l[l] = pick_hold(); end
        else hold_l[l]--;
      end
      if (force_off) begin
        if (kill_hold == 0) force_off = 1'b0; else kill_hold--;
      end else if ($urandom_range(0, 599) == 0) begin
        force_off = 1'b1;
        kill_hold = $urandom_range(0, 11);
      end
      step();
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule